// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This unit produces data addresses and keeps the pointers that go with them. It holds four independent pointer contexts. Each context keeps a current index, a buffer base, a buffer length, a signed modifier and a bit-reverse width. On each request the caller picks a context, an addressing mode and an access size. One cycle later the unit returns the address to use and the pointer value it has written back. A request on the next cycle therefore already sees the updated pointer.

The modulo wrap works for a buffer of any length placed at any base, so no power-of-two alignment is needed. A length of zero turns a context into a plain linear pointer. The modifier is counted in access units, so the step doubles for dual-word accesses and quadruples for quad-word accesses. A bit-reverse mode lets the carry run from the top bit of a programmed window down to its bottom bit, which walks an FFT buffer in reordered sequence. Contexts are loaded through a field-write port.

The control is a two-state machine. S_IDLE means no response is presented. S_RESP means a response is valid. The transition S_IDLE->S_RESP and S_RESP->S_RESP is taken when req_valid is high. S_RESP->S_IDLE and S_IDLE->S_IDLE are taken when it is low.

Top module: `circ_addr_gen`

## Requirements
- R1: The four contexts are independent. A request or field write on one context leaves the fields of every other context unchanged.
- R2: Mode 0 (post-modify) returns the current index as the address. The index then becomes the wrapped sum of the index and the step.
- R3: Mode 1 (pre-modify) returns the wrapped sum of the index and the step as the address. The index is updated to that same value.
- R4: With a nonzero length, a sum at or above base+length has the length subtracted.
- R5: With a nonzero length, a sum below base has the length added.
- R6: With a length of zero, no wrap is applied and the pointer moves linearly.
- R7: The step is the modifier scaled by the access size. Size 0 (single) uses the modifier times 1. Size 1 (dual) uses times 2. Sizes 2 and 3 (quad) use times 4.
- R8: Mode 2 (bit-reverse) returns the index as the address. It adds the step to the low W bits of the index with the carry running from bit W-1 toward bit 0, and drops the carry out of bit 0. Bits at W and above are kept. W is the reverse-width field; a value of 0 leaves the index unchanged, and values of 32 or more cover all bits.
- R9: Mode 3 (hold) returns the index as both the address and the updated index, and it writes nothing.
- R10: resp_valid is high in exactly the cycle after a cycle with req_valid high. A request in that cycle on the same context uses the index that was just written back.
- R11: After reset, resp_valid, resp_addr, resp_index and every context field are zero.
- R12: Field writes use the codes 0 index, 1 base, 2 length, 3 modifier and 4 reverse width; codes 5 to 7 are ignored. A field write takes effect in the following cycle. If a request updates the index of the context being written in the same cycle, the request's update wins over a write to its index field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Context field write strobe |
| cfg_ctx | input | 2 | Context written |
| cfg_fld | input | 3 | Field code (R12) |
| cfg_data | input | 32 | Field value |
| req_valid | input | 1 | Address request |
| req_ctx | input | 2 | Context used by the request |
| req_mode | input | 2 | 0 post, 1 pre, 2 bit-reverse, 3 hold |
| req_size | input | 2 | 0 single, 1 dual, 2 or 3 quad |
| resp_valid | output | 1 | Response valid, one cycle after the request |
| resp_addr | output | 32 | Address for the access |
| resp_index | output | 32 | Index written back to the context |

## Verification
The bench targets the wrap at both edges of a buffer. A design that compared against the end with the wrong inequality, or corrected only one side, would leave the pointer one buffer length outside the buffer. It drives back-to-back requests on one context. A design that read a stale index would repeat an address instead of advancing. It steps a bit-reverse window through a full cycle with upper bits set. A forward-carry adder would produce a linear sequence or corrupt bits above the window. It also covers size scaling, zero-length linear contexts, and a field write that collides with a request. Any of these faults shows up as a mismatched address or index against the bench model.

// File: rtl/circ_agu_pkg.sv
package circ_agu_pkg;

    typedef enum logic [1:0] {
        MODE_POST  = 2'd0,
        MODE_PRE   = 2'd1,
        MODE_BREV  = 2'd2,
        MODE_HOLD  = 2'd3
    } agu_mode_e;

    typedef enum logic [2:0] {
        FLD_INDEX = 3'd0,
        FLD_BASE  = 3'd1,
        FLD_LEN   = 3'd2,
        FLD_MOD   = 3'd3,
        FLD_REVW  = 3'd4
    } agu_fld_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } agu_state_e;

endpackage

// File: rtl/circ_agu_ctx_bank.sv
module circ_agu_ctx_bank #(
    parameter int N_CTX = 4,
    parameter int AW    = 32,
    localparam int CW   = $clog2(N_CTX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_ctx,
    input  logic [2:0]    cfg_fld,
    input  logic [AW-1:0] cfg_data,
    input  logic          upd_en,
    input  logic [CW-1:0] upd_ctx,
    input  logic [AW-1:0] upd_idx,
    input  logic [CW-1:0] rd_ctx,
    output logic [AW-1:0] rd_idx,
    output logic [AW-1:0] rd_base,
    output logic [AW-1:0] rd_len,
    output logic [AW-1:0] rd_mod,
    output logic [AW-1:0] rd_revw
);
    import circ_agu_pkg::*;

    logic [AW-1:0] idx_q  [N_CTX];
    logic [AW-1:0] base_q [N_CTX];
    logic [AW-1:0] len_q  [N_CTX];
    logic [AW-1:0] mod_q  [N_CTX];
    logic [AW-1:0] revw_q [N_CTX];

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        logic wr_here;
        logic up_here;
        assign wr_here = cfg_we && (cfg_ctx == CW'(c));
        assign up_here = upd_en && (upd_ctx == CW'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                idx_q[c]  <= '0;
                base_q[c] <= '0;
                len_q[c]  <= '0;
                mod_q[c]  <= '0;
                revw_q[c] <= '0;
            end else begin
                if (up_here) begin
                    idx_q[c] <= upd_idx;
                end else if (wr_here && cfg_fld == FLD_INDEX) begin
                    idx_q[c] <= cfg_data;
                end
                if (wr_here && cfg_fld == FLD_BASE) base_q[c] <= cfg_data;
                if (wr_here && cfg_fld == FLD_LEN)  len_q[c]  <= cfg_data;
                if (wr_here && cfg_fld == FLD_MOD)  mod_q[c]  <= cfg_data;
                if (wr_here && cfg_fld == FLD_REVW) revw_q[c] <= cfg_data;
            end
        end
    end

    assign rd_idx  = idx_q[rd_ctx];
    assign rd_base = base_q[rd_ctx];
    assign rd_len  = len_q[rd_ctx];
    assign rd_mod  = mod_q[rd_ctx];
    assign rd_revw = revw_q[rd_ctx];

endmodule

// File: rtl/circ_agu_modulo.sv
module circ_agu_modulo #(
    parameter int AW = 32,
    localparam int EW = AW + 2
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] wrapped
);
    logic signed [EW-1:0] sum;
    logic signed [EW-1:0] lo_lim;
    logic signed [EW-1:0] hi_lim;
    logic signed [EW-1:0] len_x;
    logic signed [EW-1:0] fixed;

    always_comb begin
        sum    = $signed({2'b00, idx}) + $signed({{2{step[AW-1]}}, step});
        len_x  = $signed({2'b00, len});
        lo_lim = $signed({2'b00, base});
        hi_lim = lo_lim + len_x;
        fixed  = sum;
        if (len != '0) begin
            if (sum >= hi_lim) begin
                fixed = sum - len_x;
            end else if (sum < lo_lim) begin
                fixed = sum + len_x;
            end
        end
        wrapped = fixed[AW-1:0];
    end

endmodule

// File: rtl/circ_agu_bitrev.sv
module circ_agu_bitrev #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] width,
    output logic [AW-1:0] result
);
    logic [AW-1:0] win_mask;
    logic [AW-1:0] a_rev;
    logic [AW-1:0] b_rev;
    logic [AW-1:0] s_rev;
    logic [AW-1:0] s_fwd;
    logic [AW-1:0] a_win;
    logic [AW-1:0] b_win;
    logic [AW-1:0] shamt;

    always_comb begin
        if (width >= AW) begin
            win_mask = '1;
            shamt    = '0;
        end else begin
            shamt    = AW[AW-1:0] - width;
            win_mask = {AW{1'b1}} >> shamt;
        end
        a_win = idx & win_mask;
        b_win = step & win_mask;
        for (int k = 0; k < AW; k++) begin
            a_rev[AW-1-k] = a_win[k];
            b_rev[AW-1-k] = b_win[k];
        end
        s_rev = a_rev + b_rev;
        for (int k = 0; k < AW; k++) begin
            s_fwd[AW-1-k] = s_rev[k];
        end
        result = (idx & ~win_mask) | (s_fwd & win_mask);
    end

endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
    parameter int N_CTX = 4,
    parameter int AW    = 32,
    localparam int CW   = $clog2(N_CTX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_ctx,
    input  logic [2:0]    cfg_fld,
    input  logic [AW-1:0] cfg_data,
    input  logic          req_valid,
    input  logic [CW-1:0] req_ctx,
    input  logic [1:0]    req_mode,
    input  logic [1:0]    req_size,
    output logic          resp_valid,
    output logic [AW-1:0] resp_addr,
    output logic [AW-1:0] resp_index
);
    import circ_agu_pkg::*;

    agu_state_e    state_q, state_d;
    logic [AW-1:0] cur_idx, cur_base, cur_len, cur_mod, cur_revw;
    logic [AW-1:0] step;
    logic [AW-1:0] wrap_val;
    logic [AW-1:0] brev_val;
    logic [AW-1:0] addr_d, nidx_d;
    logic          writes_back;
    logic [AW-1:0] addr_q, nidx_q;

    circ_agu_ctx_bank #(.N_CTX(N_CTX), .AW(AW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_ctx  (cfg_ctx),
        .cfg_fld  (cfg_fld),
        .cfg_data (cfg_data),
        .upd_en   (req_valid && writes_back),
        .upd_ctx  (req_ctx),
        .upd_idx  (nidx_d),
        .rd_ctx   (req_ctx),
        .rd_idx   (cur_idx),
        .rd_base  (cur_base),
        .rd_len   (cur_len),
        .rd_mod   (cur_mod),
        .rd_revw  (cur_revw)
    );

    always_comb begin
        unique case (req_size)
            2'd0:    step = cur_mod;
            2'd1:    step = cur_mod << 1;
            default: step = cur_mod << 2;
        endcase
    end

    circ_agu_modulo #(.AW(AW)) u_mod (
        .idx     (cur_idx),
        .base    (cur_base),
        .len     (cur_len),
        .step    (step),
        .wrapped (wrap_val)
    );

    circ_agu_bitrev #(.AW(AW)) u_brev (
        .idx    (cur_idx),
        .step   (step),
        .width  (cur_revw),
        .result (brev_val)
    );

    always_comb begin
        unique case (agu_mode_e'(req_mode))
            MODE_POST: begin
                addr_d = cur_idx;  nidx_d = wrap_val; writes_back = 1'b1;
            end
            MODE_PRE: begin
                addr_d = wrap_val; nidx_d = wrap_val; writes_back = 1'b1;
            end
            MODE_BREV: begin
                addr_d = cur_idx;  nidx_d = brev_val; writes_back = 1'b1;
            end
            MODE_HOLD: begin
                addr_d = cur_idx;  nidx_d = cur_idx;  writes_back = 1'b0;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            S_IDLE: state_d = req_valid ? S_RESP : S_IDLE;
            S_RESP: state_d = req_valid ? S_RESP : S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            nidx_q <= '0;
        end else if (req_valid) begin
            addr_q <= addr_d;
            nidx_q <= nidx_d;
        end
    end

    always_comb begin
        resp_valid = (state_q == S_RESP);
        resp_addr  = addr_q;
        resp_index = nidx_q;
    end

endmodule

// File: rtl/circ_addr_gen_chk.sv
module circ_addr_gen_chk #(
    parameter int CW = 2,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          req_valid,
    input logic [CW-1:0] req_ctx,
    input logic [1:0]    req_mode,
    input logic          resp_valid,
    input logic [AW-1:0] resp_addr,
    input logic [AW-1:0] resp_index
);
    p_resp_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    p_no_resp_unasked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    p_pre_addr_is_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd1) |=> (resp_addr == resp_index));

    p_hold_keeps_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd3) |=> (resp_addr == resp_index));

    p_chain_uses_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && resp_valid && req_ctx == $past(req_ctx) && req_mode != 2'd1
         && !cfg_we && !$past(cfg_we)) |=> (resp_addr == $past(resp_index)));

    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            p_reset_quiet_r11: assert (resp_valid == 1'b0);
        end
    end

endmodule

bind circ_addr_gen circ_addr_gen_chk #(.CW(CW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .req_valid  (req_valid),
    .req_ctx    (req_ctx),
    .req_mode   (req_mode),
    .resp_valid (resp_valid),
    .resp_addr  (resp_addr),
    .resp_index (resp_index)
);

// File: tb/test_circ_addr_gen.sv
module test_circ_addr_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ctx = '0;
    logic [2:0]  cfg_fld = '0;
    logic [31:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_ctx = '0;
    logic [1:0]  req_mode = '0;
    logic [1:0]  req_size = '0;
    logic        resp_valid;
    logic [31:0] resp_addr;
    logic [31:0] resp_index;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_idx [4];
    logic [31:0] m_base[4];
    logic [31:0] m_len [4];
    logic [31:0] m_mod [4];
    logic [31:0] m_revw[4];

    circ_addr_gen i_circ_addr_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctx(cfg_ctx),
        .cfg_fld(cfg_fld), .cfg_data(cfg_data), .req_valid(req_valid),
        .req_ctx(req_ctx), .req_mode(req_mode), .req_size(req_size),
        .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_index(resp_index)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] f_step(logic [31:0] m, logic [1:0] sz);
        if (sz == 2'd0) return m;
        if (sz == 2'd1) return m << 1;
        return m << 2;
    endfunction

    function automatic logic [31:0] f_wrap(logic [31:0] i, logic [31:0] b,
                                           logic [31:0] l, logic [31:0] st);
        longint s;
        longint lim;
        s   = longint'(i) + longint'($signed(st));
        lim = longint'(b) + longint'(l);
        if (l != 0) begin
            if (s >= lim) s = s - longint'(l);
            else if (s < longint'(b)) s = s + longint'(l);
        end
        return s[31:0];
    endfunction

    function automatic logic [31:0] f_brev(logic [31:0] i, logic [31:0] st,
                                           logic [31:0] w);
        logic [31:0] r;
        logic        cy;
        logic [1:0]  s;
        int          top;
        r   = i;
        cy  = 1'b0;
        top = (w >= 32) ? 32 : int'(w);
        for (int k = top - 1; k >= 0; k--) begin
            s     = {1'b0, r[k]} + {1'b0, st[k]} + {1'b0, cy};
            r[k]  = s[0];
            cy    = s[1];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic model_req(int c, logic [1:0] md, logic [1:0] sz,
                             output logic [31:0] ea, output logic [31:0] en);
        logic [31:0] st;
        logic [31:0] w;
        st = f_step(m_mod[c], sz);
        w  = f_wrap(m_idx[c], m_base[c], m_len[c], st);
        case (md)
            2'd0: begin ea = m_idx[c]; en = w; end
            2'd1: begin ea = w;        en = w; end
            2'd2: begin ea = m_idx[c]; en = f_brev(m_idx[c], st, m_revw[c]); end
            default: begin ea = m_idx[c]; en = m_idx[c]; end
        endcase
        m_idx[c] = en;
    endtask

    task automatic cfg(int c, int f, logic [31:0] d);
        cfg_we = 1'b1; cfg_ctx = 2'(c); cfg_fld = 3'(f); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (f)
            0: m_idx[c]  = d;
            1: m_base[c] = d;
            2: m_len[c]  = d;
            3: m_mod[c]  = d;
            4: m_revw[c] = d;
            default: ;
        endcase
    endtask

    task automatic req(string tag, int c, logic [1:0] md, logic [1:0] sz);
        logic [31:0] ea, en;
        req_valid = 1'b1; req_ctx = 2'(c); req_mode = md; req_size = sz;
        model_req(c, md, sz, ea, en);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, {31'd0, resp_valid}, 32'd1);
        check({tag, " addr"}, resp_addr, ea);
        check({tag, " index"}, resp_index, en);
    endtask

    task automatic setup(int c, logic [31:0] b, logic [31:0] l,
                         logic [31:0] m, logic [31:0] i);
        cfg(c, 1, b); cfg(c, 2, l); cfg(c, 3, m); cfg(c, 0, i);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] ea, en, first_n;
        void'($urandom(32'd7741));
        for (int c = 0; c < 4; c++) begin
            m_idx[c] = '0; m_base[c] = '0; m_len[c] = '0; m_mod[c] = '0; m_revw[c] = '0;
        end
        repeat (3) @(negedge clk);
        check("R11 resp_valid in reset", {31'd0, resp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 resp_addr after reset", resp_addr, 32'd0);
        check("R11 resp_index after reset", resp_index, 32'd0);
        for (int c = 0; c < 4; c++) req("R11 context zero", c, 2'd3, 2'd0);

        // R4 R2: post-modify past the top of a buffer at base 100, length 10
        setup(0, 32'd100, 32'd10, 32'd3, 32'd108);
        setup(1, 32'h1000, 32'd20, 32'd2, 32'h1003);
        req("R4 R2 post wrap top", 0, 2'd0, 2'd0);
        check("R4 wrapped value", m_idx[0], 32'd101);
        // R5 R3: pre-modify below base
        cfg(0, 3, -32'sd3);
        req("R5 R3 pre wrap bottom", 0, 2'd1, 2'd0);
        check("R5 wrapped value", m_idx[0], 32'd108);
        // R1: context 1 untouched
        req("R1 other context untouched", 1, 2'd3, 2'd0);
        // R7: size scaling
        req("R7 dual step", 1, 2'd0, 2'd1);
        req("R7 quad step", 1, 2'd0, 2'd2);
        req("R7 size3 quad step", 1, 2'd0, 2'd3);
        req("R7 single step", 1, 2'd1, 2'd0);
        // R6: linear with length zero
        setup(2, 32'd0, 32'd0, 32'd5, 32'd7);
        req("R6 linear 1", 2, 2'd0, 2'd0);
        req("R6 linear 2", 2, 2'd0, 2'd2);
        check("R6 linear final", m_idx[2], 32'd32);
        // R8: bit-reverse window of 3 bits, upper bits set
        setup(3, 32'd0, 32'd0, 32'd4, 32'h40);
        cfg(3, 4, 32'd3);
        for (int k = 0; k < 8; k++) req("R8 bitrev walk", 3, 2'd2, 2'd0);
        check("R8 walk returns", m_idx[3], 32'h40);
        cfg(3, 4, 32'd0);
        req("R8 zero width", 3, 2'd2, 2'd0);
        // R9: hold does not write
        req("R9 hold", 0, 2'd3, 2'd2);
        req("R9 hold again", 0, 2'd3, 2'd0);
        // R10: back-to-back on same context
        req_valid = 1'b1; req_ctx = 2'd0; req_mode = 2'd0; req_size = 2'd0;
        model_req(0, 2'd0, 2'd0, ea, en);
        first_n = en;
        @(negedge clk);
        check("R10 first addr", resp_addr, ea);
        model_req(0, 2'd0, 2'd0, ea, en);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 chained addr", resp_addr, first_n);
        check("R10 chained index", resp_index, en);
        @(negedge clk);
        check("R10 idle after", {31'd0, resp_valid}, 32'd0);
        // R12: collision of index write and request
        cfg_we = 1'b1; cfg_ctx = 2'd0; cfg_fld = 3'd0; cfg_data = 32'd500;
        req_valid = 1'b1; req_ctx = 2'd0; req_mode = 2'd0; req_size = 2'd0;
        model_req(0, 2'd0, 2'd0, ea, en);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R12 collision addr", resp_addr, ea);
        req("R12 request update wins", 0, 2'd3, 2'd0);
        cfg(1, 6, 32'hDEAD);
        req("R12 ignored field code", 1, 2'd3, 2'd0);
        req("R12 ignored field no side effect", 1, 2'd1, 2'd0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int c;
            c = int'($urandom % 4);
            if ($urandom % 8 == 0) begin
                logic [31:0] b, l, m;
                b = $urandom % 1000000;
                l = ($urandom % 4 == 0) ? 32'd0 : 32'd4 + ($urandom % 500);
                m = (l == 0) ? ($urandom % 64) : ($urandom % (l / 4 + 1));
                if ($urandom % 2) m = -m;
                setup(c, b, l, m, b + ((l == 0) ? 32'd0 : ($urandom % l)));
                cfg(c, 4, $urandom % 10);
            end
            req("R2 R3 R4 R5 R7 R8 random", c, 2'($urandom % 4), 2'($urandom % 4));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule